// File: doc/BRIEF.md
# Filtered Quadrature Decoder Counter

This block turns the two phase signals of a rotary shaft encoder into an 8-bit position count that moves up or down with the shaft. Each phase is first passed through a two-stage synchronizer. It is then cleaned by a consensus filter. The filter takes samples only when an external timer asserts a sample enable. A filtered phase takes a new level only after three samples in a row agree on it, so narrow glitches never reach the decoder.

The decoder counts in 4x mode: every edge of either filtered phase moves the count by one. The direction follows the Gray-code order of the phase pair. If both phases change in the same step, the move is illegal: the count holds and an error bit is latched. When the count wraps from 255 to 0 or from 0 to 255, a sticky wrap flag is set, and this flag drives the interrupt line. Software reads the count and the status through a small register port. It clears status bits by writing ones to them, and it zeroes the count by writing to the count register.

Top module: `quad_decoder`

## Requirements
- R1: After a synchronous reset, the count, the wrap flag, the error flag, `irq` and `reg_rdata` are all zero, and the filtered phase pair is 00.
- R2: A filtered phase changes only on a clock where `sample_en` is high. It takes the new level on the third consecutive enabled sample that sees that level. Two enabled samples are not enough, and a glitch that lasts two clocks while `sample_en` is held high is ignored.
- R3: The phase pair is written {`enc_a`,`enc_b`}. A step along 00, 01, 11, 10 and back to 00 adds one to the count.
- R4: A step in the reverse order (00, 10, 11, 01, 00) subtracts one from the count.
- R5: A step in which both filtered phases change at once leaves the count unchanged and sets the error flag, which is status bit 1.
- R6: An up step from 255 gives 0 and sets the wrap flag, which is status bit 0.
- R7: A down step from 0 gives 255 and sets the wrap flag.
- R8: Writing status (address 1) with a 1 in a bit clears that flag, and a 0 leaves it as it is. A wrap in the same clock as the clear leaves the wrap flag set.
- R9: Any write to address 0 sets the count to 0 and leaves both flags unchanged. If a step arrives in the same clock, the clear wins.
- R10: `reg_rdata` is registered and shows, one clock after `reg_addr` is applied: the count for address 0, {6'b0, error, wrap} for address 1, and 0 for addresses 2 and 3.
- R11: `irq` follows the wrap flag. With `sample_en` held high, a phase change at the pins raises `irq` on the sixth rising edge after the change and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Filter sample strobe from a timer |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Wrap interrupt, level |

## Verification
With `sample_en` held high, a pin change passes through two synchronizer edges and three filter samples, so the filtered phase flips on edge five and the count and flags update on edge six. A register read then needs one more edge. The bench checks `irq` at the falling edge just after edge five and again just after edge six. It times the same-cycle clear and wrap by that same edge count. The random walk waits a settling gap sized from the sample period before each read, so every count and status comparison is made on a settled result.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd1;
  localparam int STAT_WRAP_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;

  // Position of a phase pair {a,b} along the up sequence 00,01,11,10
  function automatic logic [1:0] phase_pos(input logic [1:0] ab);
    phase_pos = {ab[1], ab[1] ^ ab[0]};
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic din,
  output logic dout
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [HIST_W-1:0] hist;
  logic all_hi, all_lo;

  always_comb begin
    all_hi = &{hist, din};
    all_lo = ~|{hist, din};
  end

  generate
    if (HIST_W == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (rst)            hist <= '0;
        else if (sample_en) hist <= din;
      end
    end else begin : g_long
      always_ff @(posedge clk) begin
        if (rst)            hist <= '0;
        else if (sample_en) hist <= {hist[HIST_W-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else if (sample_en) begin
      if (all_hi)      dout <= 1'b1;
      else if (all_lo) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab,
  output logic       step_up,
  output logic       step_dn,
  output logic       step_bad
);
  logic [1:0] prev_ab;
  logic [1:0] delta;

  always_ff @(posedge clk) begin
    if (rst) prev_ab <= 2'b00;
    else     prev_ab <= ab;
  end

  always_comb begin
    delta    = phase_pos(ab) - phase_pos(prev_ab);
    step_up  = (delta == 2'd1);
    step_dn  = (delta == 2'd3);
    step_bad = (delta == 2'd2);
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             up,
  input  logic             dn,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_comb
    wrap_evt = !clr && ((up && cnt == CNT_MAX) || (dn && cnt == '0));

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (up)  cnt <= cnt + 1'b1;
    else if (dn)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sample_en,
  input  logic                  enc_a,
  input  logic                  enc_b,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [CNT_W-1:0]      reg_wdata,
  output logic [CNT_W-1:0]      reg_rdata,
  output logic                  irq
);
  logic [1:0] raw_ab, sync_ab, filt_ab;
  logic step_up, step_dn, step_bad;
  logic [CNT_W-1:0] cnt;
  logic wrap_evt, cnt_clr, w1c_wrap, w1c_err;
  logic wrap_flag, err_flag;
  logic unused_wdata;

  assign raw_ab = {enc_a, enc_b};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_phase
      qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw_ab[g]), .dout(sync_ab[g])
      );
      qdec_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .din(sync_ab[g]), .dout(filt_ab[g])
      );
    end
  endgenerate

  qdec_step u_step (
    .clk(clk), .rst(rst), .ab(filt_ab),
    .step_up(step_up), .step_dn(step_dn), .step_bad(step_bad)
  );

  always_comb begin
    cnt_clr  = reg_wr && (reg_addr == ADDR_COUNT);
    w1c_wrap = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[STAT_WRAP_BIT];
    w1c_err  = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[STAT_ERR_BIT];
    unused_wdata = ^reg_wdata;
  end

  qdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .up(step_up), .dn(step_dn),
    .cnt(cnt), .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      wrap_flag <= (wrap_flag && !w1c_wrap) || wrap_evt;
      err_flag  <= (err_flag && !w1c_err) || step_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_COUNT:  reg_rdata <= cnt;
        ADDR_STATUS: begin
          reg_rdata <= '0;
          reg_rdata[STAT_WRAP_BIT] <= wrap_flag;
          reg_rdata[STAT_ERR_BIT]  <= err_flag;
        end
        default:     reg_rdata <= '0;
      endcase
    end
  end

  assign irq = wrap_flag;
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_en,
  input logic [1:0]       filt_ab,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_clr,
  input logic             wrap_flag,
  input logic             err_flag,
  input logic             w1c_wrap,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_filter_holds: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(filt_ab));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

  a_r5_bad_holds_count: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr ##1 $rose(err_flag) |-> $stable(cnt));

  a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr && cnt == CMAX ##1 cnt == '0 |-> wrap_flag);

  a_r7_wrap_down: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr && cnt == '0 ##1 cnt == CMAX |-> wrap_flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    wrap_flag && !w1c_wrap |=> wrap_flag);

  a_r9_clear_count: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cnt == '0);

  a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == wrap_flag);
endmodule

bind quad_decoder qdec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sample_en(sample_en), .filt_ab(filt_ab),
  .cnt(cnt), .cnt_clr(cnt_clr), .wrap_flag(wrap_flag), .err_flag(err_flag),
  .w1c_wrap(w1c_wrap), .irq(irq)
);

// File: tb/quad_decoder_test.sv
module quad_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic       enc_a = 1'b0, enc_b = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  int se_period = 1;
  bit se_manual = 1'b0;
  logic [7:0] exp_cnt = 8'd0;
  logic [1:0] cur_ab = 2'b00;
  bit exp_wrap = 1'b0, exp_err = 1'b0;

  quad_decoder uut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .enc_a(enc_a), .enc_b(enc_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  initial begin : se_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (!se_manual) begin
        sample_en = (ph == 0);
        ph = (ph + 1 >= se_period) ? 0 : ph + 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung (actual running, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [1:0] pos_of(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction
  function automatic logic [1:0] ab_of(input logic [1:0] p);
    return {p[1], p[1] ^ p[0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic settle();
    repeat (6 + 3 * se_period + 2) @(negedge clk);
  endtask

  // kind: 0 up, 1 down, 2 illegal
  task automatic move(input int kind);
    logic [1:0] np;
    np = pos_of(cur_ab) + ((kind == 0) ? 2'd1 : (kind == 1) ? 2'd3 : 2'd2);
    if (kind == 0) begin
      if (exp_cnt == 8'hFF) exp_wrap = 1'b1;
      exp_cnt = exp_cnt + 8'd1;
    end else if (kind == 1) begin
      if (exp_cnt == 8'h00) exp_wrap = 1'b1;
      exp_cnt = exp_cnt - 8'd1;
    end else exp_err = 1'b1;
    cur_ab = ab_of(np);
    @(negedge clk); {enc_a, enc_b} = cur_ab;
  endtask

  task automatic check_regs(input string req);
    logic [7:0] d;
    rd(2'd0, d); check({req, " count"}, d, exp_cnt);
    rd(2'd1, d); check({req, " status"}, d, {6'b0, exp_err, exp_wrap});
  endtask

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'd0);
    check("R1 rdata", reg_rdata, 8'd0);
    @(negedge clk); rst = 1'b0;
    check_regs("R1");

    // R10 unused addresses read zero
    rd(2'd2, d); check("R10 addr2", d, 8'd0);
    rd(2'd3, d); check("R10 addr3", d, 8'd0);

    // R7 + R11: down from 0, irq timing
    se_period = 1;
    repeat (4) @(negedge clk);
    move(1);
    repeat (5) @(negedge clk);
    check("R11 irq before edge six", {7'b0, irq}, 8'd0);
    @(negedge clk);
    check("R11 irq at edge six", {7'b0, irq}, 8'd1);
    settle(); check_regs("R7");

    // R8 write zero no effect, write one clears
    wr(2'd1, 8'd0); check_regs("R8 write zero");
    wr(2'd1, 8'd1); exp_wrap = 1'b0; check_regs("R8 clear");
    check("R8 irq cleared", {7'b0, irq}, 8'd0);

    // R6 up from 255
    move(0); settle(); check_regs("R6");

    // R8 clear in same cycle as a wrap keeps flag
    move(1);
    repeat (5) @(negedge clk);
    reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 8'd1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'd0;
    settle(); check_regs("R8 clear with wrap");
    wr(2'd1, 8'd1); exp_wrap = 1'b0;

    // R3 / R4 directed
    for (int i = 0; i < 4; i++) begin move(0); settle(); end
    check_regs("R3 up four");
    for (int i = 0; i < 2; i++) begin move(1); settle(); end
    check_regs("R4 down two");

    // R9 count clear keeps flags
    move(0); settle();
    wr(2'd0, 8'hA5); exp_cnt = 8'd0; check_regs("R9 clear count");
    move(0); settle(); check_regs("R9 count resumes");

    // R2 glitch of two clocks ignored
    @(negedge clk); enc_a = ~enc_a;
    repeat (2) @(negedge clk); enc_a = ~enc_a;
    settle(); check_regs("R2 glitch");

    // R2 only enabled samples count; third one flips
    se_manual = 1'b1; @(negedge clk); sample_en = 1'b0;
    move(0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      sample_en = 1'b1; @(negedge clk); sample_en = 1'b0; repeat (3) @(negedge clk);
    end
    rd(2'd0, d); check("R2 two samples", d, exp_cnt - 8'd1);
    sample_en = 1'b1; @(negedge clk); sample_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R2 third sample", d, exp_cnt);
    se_manual = 1'b0;

    // R5 illegal step
    move(2); settle(); check_regs("R5 illegal");
    wr(2'd1, 8'd2); exp_err = 1'b0; check_regs("R5 err cleared");

    // random walk with varied sample periods
    for (int i = 0; i < 80; i++) begin
      se_period = 1 + ($urandom % 3);
      if (($urandom % 10) == 0) begin move(2); settle(); check_regs("R5 random"); end
      else if ($urandom % 2) begin move(0); settle(); check_regs("R3 random"); end
      else begin move(1); settle(); check_regs("R4 random"); end
      if (($urandom % 8) == 0) begin
        wr(2'd1, 8'd3); exp_wrap = 1'b0; exp_err = 1'b0;
      end
    end

    // R6 walk up over the top
    wr(2'd0, 8'd0); exp_cnt = 8'd0; wr(2'd1, 8'd3); exp_wrap = 1'b0; exp_err = 1'b0;
    se_period = 1;
    for (int i = 0; i < 256; i++) begin move(0); repeat (8) @(negedge clk); end
    settle(); check_regs("R6 full turn");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule